// File: doc/BRIEF.md
# Programmable Divisor Baud Clock Generator

This block produces the 16x oversampling clock for a 16550-style serial port. A 16-bit divisor is kept in two byte-wide registers, one for the low byte and one for the high byte. Each register can be written and read back on its own. A down-counter divides the reference clock by that divisor. The divisor to program is the reference frequency divided by sixteen times the wanted baud rate.

Divisors 0, 1 and 2 each have their own fixed behaviour, as follows:
- Divisor 0 divides by three.
- Divisor 1 passes out the inverted reference clock.
- Divisor 2 gives a square wave at half the reference rate.

Any larger divisor D gives a period of D cycles: two low cycles, then D-2 high cycles. A write to either register restarts the count at once with the new combined value, so a new setting never has to wait out an old long count. A one-cycle tick marks the first cycle of every output period. Downstream logic clocked by the reference clock can use it as an enable.

Top module: `baud_div_gen`

## Requirements
- R1: Both divisor bytes are 0 after reset. A write strobe for one byte stores the write data into that byte only, on the next clock edge. Both bytes can always be read back.
- R2: A write to either byte restarts the period on the next clock edge, using the updated 16-bit divisor. The first cycle after that edge is the start of a period: `baud_tick` is 1 and `baud_out` is low.
- R3: Divisor 0 gives a 3-cycle period: low, low, high.
- R4: With divisor 1, `baud_out` is the inverse of `clk` (low while `clk` is high, high while `clk` is low), and `baud_tick` is 1 on every cycle.
- R5: Divisor 2 gives a 2-cycle period, one cycle low and one cycle high, and `baud_out` toggles every cycle.
- R6: A divisor D of 3 or more gives a D-cycle period: low for the first 2 cycles, high for the other D-2.
- R7: `baud_tick` is 1 only in the first cycle of each period. Except with divisor 1, `baud_out` is low whenever `baud_tick` is 1.
- R8: While reset is held, the counter sits at the start of a divide-by-3 period (`baud_tick` = 1, `baud_out` low). After reset is released, the divide-by-3 pattern continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_lo | input | 1 | Write strobe for the divisor low byte |
| wr_hi | input | 1 | Write strobe for the divisor high byte |
| wdata | input | 8 | Write data for either byte |
| div_lo_q | output | 8 | Readback of the divisor low byte |
| div_hi_q | output | 8 | Readback of the divisor high byte |
| baud_out | output | 1 | Divided clock, 16x the baud rate |
| baud_tick | output | 1 | One-cycle pulse at the start of each output period |

## Verification
A write strobe is registered on one rising edge. The new byte value and the restarted period show up together just after that edge, with no further delay. Each following rising edge advances the pattern by one phase. The bench changes inputs and samples outputs at the falling edge. The first sample after a write is therefore phase 0, and the k-th later sample is phase k mod the period. The divide-by-one mode is combinational on the clock, so it is sampled once just after each edge of the clock, with the expected level fixed by the clock phase.

// File: rtl/baud_div_pkg.sv
// Shared definitions for the baud clock generator.
// Holds the output-mode encoding and the default geometry.
package baud_div_pkg;
    localparam int BYTE_W_DEF    = 8;
    localparam int NUM_BYTES_DEF = 2;

    typedef enum logic [1:0] {
        MODE_DIV3    = 2'd0,
        MODE_INVERT  = 2'd1,
        MODE_HALF    = 2'd2,
        MODE_GENERAL = 2'd3
    } baud_mode_e;
endpackage

// File: rtl/baud_div_latch.sv
// Byte-writable divisor storage.
// Each byte has its own write strobe, and all bytes share one data bus.
// Also presents the divisor as it will be after this cycle's writes,
// plus a load pulse, so the counter can restart on the same edge.
// Assumes: strobes are synchronous to clk.
module baud_div_latch #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 2,
    localparam int DIV_W    = BYTE_W * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] wr_en,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [DIV_W-1:0]     div_q,
    output logic [DIV_W-1:0]     div_next,
    output logic                 load
);
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        // Store one divisor byte when its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                div_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en[b])
                div_q[b*BYTE_W +: BYTE_W] <= wdata;
        end

        // Show the value this byte will hold after the edge.
        always_comb begin
            div_next[b*BYTE_W +: BYTE_W] = wr_en[b] ? wdata : div_q[b*BYTE_W +: BYTE_W];
        end
    end

    // Any byte write restarts the divider.
    always_comb begin
        load = |wr_en;
    end
endmodule

// File: rtl/baud_period_decode.sv
// Maps a divisor to its output period length and its waveform mode.
// Divisor 0 is treated as a period of three. Purely combinational.
module baud_period_decode
    import baud_div_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] divisor,
    output logic [DIV_W-1:0] period,
    output baud_mode_e       mode
);
    // Pick the period length and the waveform family.
    always_comb begin
        if (divisor == '0) begin
            period = DIV_W'(3);
            mode   = MODE_DIV3;
        end else if (divisor == DIV_W'(1)) begin
            period = divisor;
            mode   = MODE_INVERT;
        end else if (divisor == DIV_W'(2)) begin
            period = divisor;
            mode   = MODE_HALF;
        end else begin
            period = divisor;
            mode   = MODE_GENERAL;
        end
    end
endmodule

// File: rtl/baud_div_counter.sv
// Down-counter that tracks the phase within one output period.
// It runs from period-1 down to 0 and then reloads. A load restarts it at
// the top of the new period on the same edge.
// Assumes: both periods are nonzero.
module baud_div_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_period,
    input  logic [DIV_W-1:0] run_period,
    output logic [DIV_W-1:0] cnt_q
);
    localparam logic [DIV_W-1:0] RST_TOP = DIV_W'(2);

    // Step the phase counter, restarting on reset, load or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RST_TOP;
        else if (load)
            cnt_q <= load_period - DIV_W'(1);
        else if (cnt_q == '0)
            cnt_q <= run_period - DIV_W'(1);
        else
            cnt_q <= cnt_q - DIV_W'(1);
    end
endmodule

// File: rtl/baud_wave_shaper.sv
// Turns the phase count into the output waveform and the period tick.
// In invert mode the output is the inverted reference clock, taken
// combinationally. Assumes cnt < period.
module baud_wave_shaper
    import baud_div_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  baud_mode_e       mode,
    input  logic [DIV_W-1:0] period,
    input  logic [DIV_W-1:0] cnt,
    output logic             baud_out,
    output logic             baud_tick
);
    localparam int LOW_CYCLES = 2;

    // Build the output level for the active mode.
    always_comb begin
        unique case (mode)
            MODE_INVERT: baud_out = ~clk;
            MODE_HALF:   baud_out = (cnt == '0);
            default:     baud_out = (cnt < (period - DIV_W'(LOW_CYCLES)));
        endcase
    end

    // Mark the first cycle of every period.
    always_comb begin
        baud_tick = (cnt == (period - DIV_W'(1)));
    end
endmodule

// File: rtl/baud_div_gen.sv
// Top of the programmable baud clock generator.
// Wires the divisor storage, the period decode of the current and the
// next divisor, the phase counter and the wave shaper together.
// Assumes: one reference clock domain with a synchronous active-low reset.
module baud_div_gen
    import baud_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_lo,
    input  logic       wr_hi,
    input  logic [7:0] wdata,
    output logic [7:0] div_lo_q,
    output logic [7:0] div_hi_q,
    output logic       baud_out,
    output logic       baud_tick
);
    localparam int BYTE_W    = BYTE_W_DEF;
    localparam int NUM_BYTES = NUM_BYTES_DEF;
    localparam int DIV_W     = BYTE_W * NUM_BYTES;

    logic [NUM_BYTES-1:0] wr_en;
    logic [DIV_W-1:0]     div_q;
    logic [DIV_W-1:0]     div_next;
    logic                 load;
    logic [DIV_W-1:0]     run_period;
    logic [DIV_W-1:0]     load_period;
    baud_mode_e           run_mode;
    baud_mode_e           load_mode_unused;
    logic [DIV_W-1:0]     cnt;

    // Gather the byte strobes, low byte first.
    always_comb begin
        wr_en = {wr_hi, wr_lo};
    end

    baud_div_latch #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .div_q    (div_q),
        .div_next (div_next),
        .load     (load)
    );

    baud_period_decode #(.DIV_W(DIV_W)) u_dec_run (
        .divisor (div_q),
        .period  (run_period),
        .mode    (run_mode)
    );

    baud_period_decode #(.DIV_W(DIV_W)) u_dec_load (
        .divisor (div_next),
        .period  (load_period),
        .mode    (load_mode_unused)
    );

    baud_div_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_period (load_period),
        .run_period  (run_period),
        .cnt_q       (cnt)
    );

    baud_wave_shaper #(.DIV_W(DIV_W)) u_shape (
        .clk       (clk),
        .mode      (run_mode),
        .period    (run_period),
        .cnt       (cnt),
        .baud_out  (baud_out),
        .baud_tick (baud_tick)
    );

    // Present the stored bytes for readback.
    always_comb begin
        div_lo_q = div_q[BYTE_W-1:0];
        div_hi_q = div_q[DIV_W-1:BYTE_W];
    end
endmodule

// File: rtl/baud_div_checker.sv
// Protocol checks for baud_div_gen, attached by bind. Observes only ports.
module baud_div_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_lo,
    input logic       wr_hi,
    input logic [7:0] wdata,
    input logic [7:0] div_lo_q,
    input logic [7:0] div_hi_q,
    input logic       baud_out,
    input logic       baud_tick
);
    logic [15:0] div_w;
    logic        any_wr;

    always_comb begin
        div_w  = {div_hi_q, div_lo_q};
        any_wr = wr_lo | wr_hi;
    end

    p_lo_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> div_lo_q == $past(wdata));

    p_hi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(div_hi_q));

    p_reload_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |=> baud_tick && (div_w == 16'd1 || !baud_out));

    p_div3_second_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_w == 16'd0 && baud_tick && !any_wr) |=> !baud_out && !baud_tick);

    p_half_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_w == 16'd2 && $past(div_w) == 16'd2 && !$past(any_wr))
            |-> baud_out != $past(baud_out));

    p_general_second_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_w >= 16'd3 && baud_tick && !any_wr) |=> !baud_out);

    p_tick_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && div_w != 16'd1) |-> !baud_out);
endmodule

bind baud_div_gen baud_div_checker u_chk (.*);

// File: tb/baud_div_gen_bench.sv
module baud_div_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] div_lo_q;
    logic [7:0] div_hi_q;
    logic       baud_out;
    logic       baud_tick;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    baud_div_gen u_baud_div_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wdata     (wdata),
        .div_lo_q  (div_lo_q),
        .div_hi_q  (div_hi_q),
        .baud_out  (baud_out),
        .baud_tick (baud_tick)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Write one byte; returns at the falling edge where phase 0 is visible.
    task automatic write_byte(input bit hi, input logic [7:0] val);
        @(negedge clk);
        wdata = val;
        wr_lo = !hi;
        wr_hi = hi;
        @(negedge clk);
        wr_lo = 1'b0;
        wr_hi = 1'b0;
    endtask

    // Compare n falling-edge samples against the phase model, from phase k0.
    task automatic check_pattern(input string req, input int div, input int k0, input int n);
        int p = (div == 0) ? 3 : div;
        for (int i = 0; i < n; i++) begin
            int ph = (k0 + i) % p;
            int exp_out = (p == 2) ? int'(ph == 1) : int'(ph >= 2);
            if (i > 0) @(negedge clk);
            check(req, "baud_out", int'(baud_out), exp_out);
            check("R7", "baud_tick", int'(baud_tick), int'(ph == 0));
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1", "div_lo_q at reset", int'(div_lo_q), 0);
        check("R1", "div_hi_q at reset", int'(div_hi_q), 0);
        check("R8", "baud_tick in reset", int'(baud_tick), 1);
        check("R8", "baud_out in reset", int'(baud_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_pattern("R8", 0, 1, 9);
    endtask

    task automatic t_div3;
        write_byte(1'b0, 8'd0);
        check_pattern("R3", 0, 0, 12);
    endtask

    task automatic t_half;
        write_byte(1'b0, 8'd2);
        check_pattern("R5", 2, 0, 10);
    endtask

    task automatic t_general_small;
        write_byte(1'b0, 8'd5);
        check("R1", "div_lo_q after write", int'(div_lo_q), 5);
        check("R1", "div_hi_q untouched", int'(div_hi_q), 0);
        check_pattern("R6", 5, 0, 15);
    endtask

    task automatic t_invert;
        write_byte(1'b0, 8'd1);
        for (int i = 0; i < 6; i++) begin
            #1;
            check("R4", "baud_out while clk low", int'(baud_out), 1);
            check("R4", "baud_tick every cycle", int'(baud_tick), 1);
            @(posedge clk);
            #1;
            check("R4", "baud_out while clk high", int'(baud_out), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_two_byte;
        write_byte(1'b0, 8'd0);
        write_byte(1'b1, 8'd1);
        check("R1", "div_hi_q after write", int'(div_hi_q), 1);
        check("R1", "div_lo_q untouched", int'(div_lo_q), 0);
        check_pattern("R2", 256, 0, 20);
        write_byte(1'b0, 8'd3);
        check_pattern("R6", 259, 0, 2 * 259 + 3);
    endtask

    task automatic t_reload;
        write_byte(1'b1, 8'h03);
        write_byte(1'b0, 8'hE8);
        check_pattern("R6", 1000, 0, 10);
        write_byte(1'b1, 8'h00);
        check("R1", "readback hi", int'(div_hi_q), 0);
        check("R1", "readback lo", int'(div_lo_q), 8'hE8);
        check_pattern("R2", 232, 0, 5);
        write_byte(1'b0, 8'd4);
        check_pattern("R2", 4, 0, 12);
    endtask

    initial begin
        t_reset();
        t_div3();
        t_half();
        t_general_small();
        t_invert();
        t_two_byte();
        t_reload();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule